// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block sits beside the byte path of a NAND flash controller and computes Reed-Solomon parity for one sector at a time. Each byte that passes on the data strobe is complemented, widened to a 10-bit symbol and shifted into a six-stage polynomial divider over GF(2^10). The divider's generator has the six consecutive roots alpha^0 to alpha^5. Because the data is complemented, a sector of all 0xFF bytes leaves the divider at zero. Its complemented parity therefore reads back as all ones, the same as erased flash.

In generate mode the six remainder symbols are the parity. Software reads them from a bank of eight complemented byte registers and writes those bytes to the spare area. In check mode software streams the sector and then the eight stored parity bytes through the same port. The divider now holds the remainder of the whole codeword. A flag in the check register reports at once whether that remainder is non-zero, and the remainder can be read from a bit-reversed bank so that software can run a decoder. The engine does not locate or correct errors.

Top module: `rs_page_ecc`

## Requirements
- R1: After a synchronous reset, the control and check registers read 0x0000, every remainder-bank word reads 0x0000 and every complemented-bank word reads 0x00FF.
- R2: In generate mode, data byte b enters as symbol {2'b00, ~b} and the first byte is the highest-degree term. After 512 bytes the engine holds d(x)*x^6 mod g(x), where g(x) is the product of (x + alpha^i) for i = 0 to 5 over GF(2^10) reduced by x^10 + x^3 + 1.
- R3: A sector of 512 bytes of 0xFF yields complemented-bank bytes that are all 0xFF and remainder-bank bytes that are all 0x00.
- R4: The 64-bit packed value P holds symbol k (the coefficient of x^(5-k)) in bits 10k+9 to 10k, and bits 63 to 60 are zero. Word address 0x10+j returns ~P[8j+7:8j] in bits 7:0 and zero in bits 15:8.
- R5: Word address 0x08+j returns P[8j+7:8j] with its bit order reversed (P bit 8j appears at bit 7) in bits 7:0 and zero in bits 15:8.
- R6: The control register is at word address 0x00. Bit 7 clears the engine, bit 6 selects generate mode (0 selects check mode) and bit 5 enables feeding. A read returns bits 6 and 5 as written and bit 7 as zero.
- R7: A control write with bit 7 set zeroes the remainder, the byte count and the error flag at the next clock edge. A strobe presented in that same cycle is dropped.
- R8: While feeding is disabled, strobes are ignored and all bank contents and the error flag hold their values.
- R9: In generate mode exactly 512 strobes are taken after a clear. Any further strobes leave the parity unchanged.
- R10: In check mode, the 512 data bytes are followed by the 8 stored complemented-bank bytes. These bytes are complemented again and unpacked per R4, and each parity symbol enters the divider on the byte that completes it. Strobes after the 520th are ignored.
- R11: Bit 7 of the check register at word address 0x01 is set from the cycle after the 520th check-mode byte exactly when the final remainder is non-zero. The other bits read zero, and the flag is never raised in generate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_valid | input | 1 | Data byte strobe |
| din | input | 8 | Data byte |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
The bench goes after these corner cases:
- **Erased page.** A missing or misplaced data complement makes a blank sector produce non-0xFF parity.
- **Bit 59 / bit 60 boundary.** A wrong packing or pad polarity shows up in the last byte.
- **Per-symbol parity alignment in check mode.** A parity symbol fed on the wrong byte makes clean codewords raise the error flag. Random sectors are encoded and then checked both clean and with one to three corrupted bytes, and the remainder is compared against an independent long division.
- **Strobe on the clear cycle.** A design that absorbs that strobe shifts the whole sector by one symbol.
- **Strobes past the end of a codeword.** A design that takes them corrupts the parity.
- **Strobes while feeding is disabled.** A design that takes them corrupts the parity.

// File: rtl/rs_page_ecc.sv
module rs_page_ecc #(
  parameter int DATA_BYTES = 512,
  parameter int SYM_W      = 10,
  parameter logic [SYM_W:0] POLY = 11'h409,
  parameter int NPAR       = 6,
  parameter int AW         = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din_valid,
  input  logic [7:0]    din,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata
);
  localparam int PBITS  = NPAR * SYM_W;
  localparam int PBYTES = (PBITS + 7) / 8;
  localparam int TOTAL  = DATA_BYTES + PBYTES;
  localparam int CW     = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] DB_C  = CW'(DATA_BYTES);
  localparam logic [CW-1:0] TOT_C = CW'(TOTAL);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CHK  = AW'(1);
  localparam logic [AW-1:0] A_REM  = AW'(8);
  localparam logic [AW-1:0] A_INV  = AW'(16);

  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gmul(sym_t a, sym_t b);
    sym_t p = '0;
    sym_t x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY[SYM_W-1:0] : '0);
    end
    return p;
  endfunction

  function automatic sym_t gcoef(int idx);
    sym_t g [NPAR+1];
    sym_t root = sym_t'(1);
    for (int i = 0; i <= NPAR; i++) g[i] = (i == 0) ? sym_t'(1) : '0;
    for (int r = 0; r < NPAR; r++) begin
      for (int i = NPAR; i > 0; i--) g[i] = g[i-1] ^ gmul(g[i], root);
      g[0] = gmul(g[0], root);
      root = gmul(root, sym_t'(2));
    end
    return g[idx];
  endfunction

  function automatic logic [7:0] brev(logic [7:0] v);
    for (int i = 0; i < 8; i++) brev[i] = v[7-i];
  endfunction

  logic [NPAR-1:0][SYM_W-1:0] rem_q, rem_nx;
  logic [8*PBYTES-1:0] pin_q, pin_nx, pk, pk_nx;
  logic [CW-1:0] cnt_q, poff;
  logic gen_q, en_q, err_q;
  logic ctrl_wr, clr, take, in_data, par_ok, shift;
  sym_t par_sym, sym_in, fb;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[15:8], reg_wdata[4:0]};
  assign ctrl_wr = reg_we && reg_addr == A_CTRL;
  assign clr     = rst || (ctrl_wr && reg_wdata[7]);
  assign in_data = cnt_q < DB_C;
  assign take    = en_q && din_valid && (gen_q ? in_data : cnt_q < TOT_C);
  assign poff    = cnt_q - DB_C;

  always_comb begin
    pin_nx  = pin_q;
    par_ok  = 1'b0;
    par_sym = '0;
    for (int j = 0; j < PBYTES; j++)
      if (poff == CW'(j)) pin_nx[8*j +: 8] = ~din;
    for (int k = 0; k < NPAR; k++)
      if (poff == CW'((SYM_W*k + SYM_W - 1) / 8)) begin
        par_ok  = 1'b1;
        par_sym = pin_nx[SYM_W*k +: SYM_W];
      end
  end

  assign sym_in = in_data ? {{(SYM_W-8){1'b0}}, ~din} : par_sym;
  assign shift  = take && (in_data || par_ok);
  assign fb     = sym_in ^ rem_q[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    localparam sym_t C = gcoef(i);
    if (i == 0) begin : g_first
      assign rem_nx[i] = gmul(fb, C);
    end else begin : g_rest
      assign rem_nx[i] = rem_q[i-1] ^ gmul(fb, C);
    end
    assign pk[SYM_W*(NPAR-1-i) +: SYM_W]    = rem_q[i];
    assign pk_nx[SYM_W*(NPAR-1-i) +: SYM_W] = rem_nx[i];
  end
  if (8*PBYTES > PBITS) begin : g_pad
    assign pk[8*PBYTES-1:PBITS]    = '0;
    assign pk_nx[8*PBYTES-1:PBITS] = '0;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rem_q <= '0;
      pin_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      gen_q <= rst ? 1'b0 : reg_wdata[6];
      en_q  <= rst ? 1'b0 : reg_wdata[5];
    end else begin
      if (ctrl_wr) begin
        gen_q <= reg_wdata[6];
        en_q  <= reg_wdata[5];
      end
      if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (!in_data) pin_q <= pin_nx;
        if (!gen_q && cnt_q == TOT_C - 1'b1) err_q <= |pk_nx;
      end
      if (shift) rem_q <= rem_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = {9'b0, gen_q, en_q, 5'b0};
    if (reg_addr == A_CHK)  reg_rdata = {8'b0, err_q, 7'b0};
    for (int j = 0; j < PBYTES; j++) begin
      if (reg_addr == A_REM + AW'(j)) reg_rdata = {8'b0, brev(pk[8*j +: 8])};
      if (reg_addr == A_INV + AW'(j)) reg_rdata = {8'b0, ~pk[8*j +: 8]};
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[7]) |=> (cnt_q == '0 && !err_q && pk == '0));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !ctrl_wr) |=> ($stable(pk) && $stable(cnt_q) && $stable(err_q)));

  assert_gen_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (gen_q && cnt_q == DB_C && !ctrl_wr) |=> (cnt_q == DB_C && $stable(pk)));

  assert_chk_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOT_C && !ctrl_wr) |=> (cnt_q == TOT_C && $stable(pk) && $stable(err_q)));

  assert_flag_mode_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> !$past(gen_q));

  assert_idle_count_R9: assert property (@(posedge clk) disable iff (rst)
    (!din_valid && !ctrl_wr) |=> $stable(cnt_q));
endmodule

// File: tb/rs_page_ecc_test.sv
module rs_page_ecc_test;
  typedef logic [9:0] sym_t;
  logic clk = 0, rst = 1, din_valid = 0, reg_we = 0;
  logic [7:0] din = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0;

  rs_page_ecc uut (.clk(clk), .rst(rst), .din_valid(din_valid), .din(din),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #10 clk = ~clk;

  logic [7:0] dat [512];
  logic [7:0] stored [8];
  sym_t seq [524];
  sym_t gp [7];

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc = 0;
    for (int i = 9; i >= 0; i--) begin
      acc = {acc[8:0], 1'b0} ^ (acc[9] ? 10'h009 : 10'h000);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

  task automatic build_gen();
    sym_t a = 1;
    sym_t t [7];
    for (int i = 0; i < 7; i++) gp[i] = (i == 0) ? 10'd1 : 10'd0;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 7; i++) t[i] = gf_mul(gp[i], a) ^ ((i > 0) ? gp[i-1] : 10'd0);
      for (int i = 0; i < 7; i++) gp[i] = t[i];
      a = gf_mul(a, 10'd2);
    end
  endtask

  task automatic ref_div(input int n, output logic [63:0] p);
    sym_t w [524];
    for (int i = 0; i < n + 6; i++) w[i] = (i < n) ? seq[i] : 10'd0;
    for (int i = 0; i < n; i++) begin
      sym_t c = w[i];
      for (int j = 1; j <= 6; j++) w[i+j] = w[i+j] ^ gf_mul(c, gp[6-j]);
    end
    p = 0;
    for (int k = 0; k < 6; k++) p[10*k +: 10] = w[n+k];
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic feed_data(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk); din_valid = 1; din = dat[i];
    end
    @(negedge clk); din_valid = 0;
  endtask

  task automatic feed_byte(input logic [7:0] b);
    @(negedge clk); din_valid = 1; din = b;
    @(negedge clk); din_valid = 0;
  endtask

  task automatic check_banks(input logic [63:0] p, input string tag);
    logic [15:0] v;
    for (int j = 0; j < 8; j++) begin
      rd_reg(5'(16 + j), v);
      chk(v == {8'h00, ~p[8*j +: 8]}, {tag, " R4 complemented bank"}, 64'(v), 64'({8'h00, ~p[8*j +: 8]}));
      rd_reg(5'(8 + j), v);
      chk(v == {8'h00, rev8(p[8*j +: 8])}, {tag, " R5 remainder bank"}, 64'(v), 64'({8'h00, rev8(p[8*j +: 8])}));
    end
  endtask

  task automatic grab_stored();
    logic [15:0] v;
    for (int j = 0; j < 8; j++) begin
      rd_reg(5'(16 + j), v);
      stored[j] = v[7:0];
    end
  endtask

  task automatic exp_write(output logic [63:0] p);
    for (int i = 0; i < 512; i++) seq[i] = {2'b00, ~dat[i]};
    ref_div(512, p);
  endtask

  task automatic exp_read(output logic [63:0] p);
    logic [63:0] q;
    for (int j = 0; j < 8; j++) q[8*j +: 8] = ~stored[j];
    for (int i = 0; i < 512; i++) seq[i] = {2'b00, ~dat[i]};
    for (int k = 0; k < 6; k++) seq[512+k] = q[10*k +: 10];
    ref_div(518, p);
  endtask

  task automatic do_read(input string tag);
    logic [63:0] p;
    logic [15:0] v;
    wr_reg(0, 16'h00A0);
    feed_data(0, 512);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); din_valid = 1; din = stored[j];
    end
    @(negedge clk); din_valid = 0;
    rd_reg(1, v);
    exp_read(p);
    chk(v == {8'h00, (p != 0), 7'b0}, {tag, " R11 check flag"}, 64'(v), 64'({8'h00, (p != 0), 7'b0}));
    wr_reg(0, 16'h0000);
    check_banks(p, {tag, " R10"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] p;
    void'($urandom(32'd2718));
    build_gen();
    repeat (3) @(negedge clk);
    rst = 0;

    rd_reg(0, v); chk(v == 0, "R1 control after reset", 64'(v), 0);
    rd_reg(1, v); chk(v == 0, "R1 check after reset", 64'(v), 0);
    check_banks(64'h0, "R1");

    wr_reg(0, 16'h00E0);
    rd_reg(0, v); chk(v == 16'h0060, "R6 control readback", 64'(v), 64'h60);

    for (int i = 0; i < 512; i++) dat[i] = 8'hFF;
    feed_data(0, 512);
    wr_reg(0, 0);
    check_banks(64'h0, "R3 blank");
    feed_byte(8'h5A);
    check_banks(64'h0, "R8 frozen");

    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 512; i++) dat[i] = 8'($urandom);
      wr_reg(0, 16'h00E0);
      feed_data(0, 512);
      feed_data(0, 5);
      rd_reg(1, v); chk(v == 0, "R11 no flag in generate mode", 64'(v), 0);
      wr_reg(0, 0);
      exp_write(p);
      check_banks(p, "R2 R9 random sector");
      grab_stored();
      do_read("R10 clean");
      feed_data(0, 3);
      check_banks(64'h0, "R10 extra strobes");
      for (int e = 0; e <= (s % 3); e++) dat[$urandom % 512] ^= 8'($urandom % 255 + 1);
      do_read("R10 corrupted");
    end

    wr_reg(0, 16'h0080);
    rd_reg(1, v); chk(v == 0, "R7 clear drops flag", 64'(v), 0);
    check_banks(64'h0, "R7 clear");

    for (int i = 0; i < 512; i++) dat[i] = 8'($urandom);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 16'h00E0; din_valid = 1; din = 8'h3C;
    @(negedge clk); reg_we = 0; din_valid = 0;
    feed_data(0, 200);
    wr_reg(0, 16'h0040);
    feed_data(0, 9);
    wr_reg(0, 16'h0060);
    feed_data(200, 512);
    wr_reg(0, 0);
    exp_write(p);
    check_banks(p, "R7 R8 strobe on clear and paused feed");

    for (int i = 0; i < 512; i++) dat[i] = (i == 511) ? 8'hFE : 8'hFF;
    wr_reg(0, 16'h00E0);
    feed_data(0, 512);
    wr_reg(0, 0);
    exp_write(p);
    check_banks(p, "R4 R5 last-byte boundary");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule